// File: doc/BRIEF.md
# Paged Program Counter Sequencer with Return Stack

This block keeps the 10-bit fetch address for a small controller that has a 1024-word instruction space. Every clock it picks the next address from a decoded control-flow class. The class comes from a decoder outside the block. The next address can be the next word, a skip over one word, a short transfer, a long transfer, a return, or a direct write of the program counter register.

Short transfers and direct writes build the address bit by bit. The low bits come from the instruction or from the ALU result. Bit 8 comes either from the instruction or from a forced zero. Bit 9 is the page-select bit from the status register. Long transfers take a full 10-bit target from the instruction word.

Calls push the address of the following word onto a two-entry hardware stack. Returns pop that stack. A return-with-literal also presents the instruction's 8-bit literal so that the working register can load it.

Top module: `pcseq_top`

## Requirements
- R1: Synchronous active-high reset sets the fetch address to 3FFh, drives the literal-load flag low and clears both stack entries to 000h, so a return issued straight after reset goes to 000h.
- R2: Flow class 0 (sequential) advances the fetch address by one on the next edge, wrapping from 3FFh to 000h.
- R3: Flow class 1 (skip) advances the fetch address by two.
- R4: Flow class 2 (short jump) loads bits 8..0 from instruction bits 8..0 and bit 9 from the page input.
- R5: Flow class 3 (short call) loads bits 7..0 from instruction bits 7..0, forces bit 8 to 0 even when instruction bit 8 is 1, takes bit 9 from the page input, and pushes the current address plus one.
- R6: Flow classes 4 (long jump) and 5 (long call) load all 10 bits from instruction bits 9..0, and the page input has no effect on them; class 5 also pushes the current address plus one.
- R7: Flow class 8 (direct write) loads bits 7..0 from the ALU input, forces bit 8 to 0 and takes bit 9 from the page input.
- R8: Flow classes 6 (return) and 7 (return-with-literal) load the most recent pushed address, in last-in first-out order across two levels.
- R9: During flow class 7 the literal output equals instruction bits 7..0 and the literal-load flag is 1; for every other class the flag is 0.
- R10: A push onto a full stack discards the oldest entry, so after three calls two returns yield the third and then the second return address.
- R11: A pop from an exhausted stack returns the last remaining entry again, without error.
- R12: Flow codes 9 to 15 behave as sequential.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flow_i | input | 4 | Decoded control-flow class |
| instr_i | input | 14 | Current instruction word |
| alu_i | input | 8 | ALU result for direct PC writes |
| page_i | input | 1 | Page-select bit from status |
| fetch_addr_o | output | 10 | Current fetch address |
| wlit_o | output | 8 | Literal for the working register |
| wlit_load_o | output | 1 | Literal is valid this cycle |

## Verification
Most internal faults in this block show up at the fetch address on the edge after the control-flow class that uses them. A wrong bit source or a wrong increment is visible after one cycle. Damage to the stack stays hidden until a return, and the lower entry stays hidden until the second return. The overflow and underflow sequences are built to reach that bottom entry. A page bit leaking into a long transfer would appear only when the page input is 1, so long transfers are driven with the page input at 1.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    localparam int PC_W   = 10;
    localparam int IW_W   = 14;
    localparam int DAT_W  = 8;
    localparam int STK_D  = 2;
    localparam int SJ_W   = 9;
    localparam int FLOW_W = 4;
    localparam logic [PC_W-1:0] PC_RST = '1;

    typedef enum logic [FLOW_W-1:0] {
        FL_SEQ    = 4'd0,
        FL_SKIP   = 4'd1,
        FL_SJMP   = 4'd2,
        FL_SCALL  = 4'd3,
        FL_LJMP   = 4'd4,
        FL_LCALL  = 4'd5,
        FL_RET    = 4'd6,
        FL_RETLIT = 4'd7,
        FL_PCWR   = 4'd8
    } flow_t;

    typedef struct packed {
        logic [PC_W-1:0] nxt;
        logic            push;
        logic            pop;
    } pc_step_t;

    function automatic logic [PC_W-1:0] pc_add(input logic [PC_W-1:0] pc, input int unsigned n);
        return pc + PC_W'(n);
    endfunction

    function automatic flow_t flow_decode(input logic [FLOW_W-1:0] code);
        if (code > FL_PCWR) return FL_SEQ;
        return flow_t'(code);
    endfunction
endpackage

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
(
    input  flow_t            flow,
    input  logic [PC_W-1:0]  imm,
    input  logic [DAT_W-1:0] alu,
    input  logic             page,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  stk_top,
    output pc_step_t         step
);
    localparam int PAD_SJ = PC_W - 1 - SJ_W;
    localparam int PAD_SC = PC_W - 1 - DAT_W;

    always_comb begin
        step      = '{nxt: pc_add(pc, 1), push: 1'b0, pop: 1'b0};
        unique case (flow)
            FL_SKIP:   step.nxt = pc_add(pc, 2);
            FL_SJMP:   step.nxt = {page, {PAD_SJ{1'b0}}, imm[SJ_W-1:0]};
            FL_SCALL: begin
                step.nxt  = {page, {PAD_SC{1'b0}}, imm[DAT_W-1:0]};
                step.push = 1'b1;
            end
            FL_LJMP:   step.nxt = imm;
            FL_LCALL: begin
                step.nxt  = imm;
                step.push = 1'b1;
            end
            FL_RET, FL_RETLIT: begin
                step.nxt = stk_top;
                step.pop = 1'b1;
            end
            FL_PCWR:   step.nxt = {page, {PAD_SC{1'b0}}, alu};
            default:   ;
        endcase
    end
endmodule

// File: rtl/pcseq_retstack.sv
module pcseq_retstack
    import pcseq_pkg::*;
#(
    parameter int DEPTH = STK_D,
    parameter int W     = PC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top
);
    logic [W-1:0] ent [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            logic [W-1:0] below;
            logic [W-1:0] above;
            if (g == 0) begin : g_first
                assign below = push_val;
            end else begin : g_mid
                assign below = ent[g-1];
            end
            if (g == DEPTH - 1) begin : g_last
                assign above = ent[g];
            end else begin : g_up
                assign above = ent[g+1];
            end
            always_ff @(posedge clk) begin
                if (rst)       ent[g] <= '0;
                else if (push) ent[g] <= below;
                else if (pop)  ent[g] <= above;
            end
        end
    endgenerate

    assign top = ent[0];

    // R10: a push moves the old top one level down
    p_push_shift_r10: assert property (@(posedge clk) disable iff (rst)
        push |=> ent[1] == $past(ent[0]));
    // R11: the bottom entry survives a pop
    p_pop_keep_r11: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> ent[DEPTH-1] == $past(ent[DEPTH-1]));
    p_excl_r8: assert property (@(posedge clk) disable iff (rst) !(push && pop));
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLOW_W-1:0] flow_i,
    input  logic [IW_W-1:0]   instr_i,
    input  logic [DAT_W-1:0]  alu_i,
    input  logic              page_i,
    output logic [PC_W-1:0]   fetch_addr_o,
    output logic [DAT_W-1:0]  wlit_o,
    output logic              wlit_load_o
);
    flow_t           flow;
    pc_step_t        step;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] stk_top;
    logic            unused_opc;

    assign flow       = flow_decode(flow_i);
    assign unused_opc = ^instr_i[IW_W-1:PC_W];

    pcseq_target u_target (
        .flow    (flow),
        .imm     (instr_i[PC_W-1:0]),
        .alu     (alu_i),
        .page    (page_i),
        .pc      (pc_q),
        .stk_top (stk_top),
        .step    (step)
    );

    pcseq_retstack #(.DEPTH(STK_D), .W(PC_W)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (step.push),
        .pop      (step.pop),
        .push_val (pc_add(pc_q, 1)),
        .top      (stk_top)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= PC_RST;
        else     pc_q <= step.nxt;
    end

    assign fetch_addr_o = pc_q;
    assign wlit_o       = instr_i[DAT_W-1:0];
    assign wlit_load_o  = !rst && (flow == FL_RETLIT);

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (flow_i == 4'd0) |=> pc_q == $past(pc_q) + 10'd1);
    p_skip_step_r3: assert property (@(posedge clk) disable iff (rst)
        (flow_i == 4'd1) |=> pc_q == $past(pc_q) + 10'd2);
    p_sjmp_page_r4: assert property (@(posedge clk) disable iff (rst)
        (flow_i == 4'd2) |=> pc_q == {$past(page_i), $past(instr_i[8:0])});
    p_scall_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (flow_i == 4'd3) |=> (pc_q[8] == 1'b0 && pc_q[9] == $past(page_i)));
    p_long_full_r6: assert property (@(posedge clk) disable iff (rst)
        (flow_i == 4'd4 || flow_i == 4'd5) |=> pc_q == $past(instr_i[9:0]));
    p_pcwr_r7: assert property (@(posedge clk) disable iff (rst)
        (flow_i == 4'd8) |=> pc_q == {$past(page_i), 1'b0, $past(alu_i)});
    p_ret_top_r8: assert property (@(posedge clk) disable iff (rst)
        (flow_i == 4'd6 || flow_i == 4'd7) |=> pc_q == $past(stk_top));
    p_hi_codes_r12: assert property (@(posedge clk) disable iff (rst)
        (flow_i > 4'd8) |=> pc_q == $past(pc_q) + 10'd1);
endmodule

// File: tb/test_pcseq_top.sv
module test_pcseq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] flow_i = '0;
    logic [13:0] instr_i = '0;
    logic [7:0] alu_i = '0;
    logic       page_i = 1'b0;
    logic [9:0] fetch_addr_o;
    logic [7:0] wlit_o;
    logic       wlit_load_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pcseq_top i_pcseq_top (
        .clk(clk), .rst(rst), .flow_i(flow_i), .instr_i(instr_i),
        .alu_i(alu_i), .page_i(page_i), .fetch_addr_o(fetch_addr_o),
        .wlit_o(wlit_o), .wlit_load_o(wlit_load_o)
    );

    // {flow, instr, alu, page, expected pc}
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {4'd0, 14'h0000, 8'h00, 1'b0, 10'h000},  // R2 wrap
        {4'd0, 14'h0000, 8'h00, 1'b1, 10'h001},  // R2
        {4'd1, 14'h0000, 8'h00, 1'b0, 10'h003},  // R3
        {4'd2, 14'h3355, 8'h00, 1'b1, 10'h355},  // R4
        {4'd3, 14'h31A7, 8'h00, 1'b0, 10'h0A7},  // R5 bit8 forced
        {4'd5, 14'h22C4, 8'h00, 1'b1, 10'h2C4},  // R6 long call
        {4'd6, 14'h0000, 8'h00, 1'b0, 10'h0A8},  // R8
        {4'd6, 14'h0000, 8'h00, 1'b0, 10'h356},  // R8
        {4'd8, 14'h0000, 8'h5E, 1'b1, 10'h25E},  // R7
        {4'd4, 14'h29F0, 8'h00, 1'b1, 10'h1F0},  // R6 page ignored
        {4'd12, 14'h0000, 8'h00, 1'b0, 10'h1F1}, // R12
        {4'd7, 14'h313C, 8'h00, 1'b0, 10'h356}   // R11 underflow
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] f, input logic [13:0] ins,
                         input logic [7:0] a, input logic p);
        @(negedge clk);
        flow_i = f; instr_i = ins; alu_i = a; page_i = p;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; flow_i = '0;
        @(posedge clk); @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        check("R1 reset pc", 32'(fetch_addr_o), 32'h3FF);
        check("R1 reset flag", 32'(wlit_load_o), 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][36:33], VEC[i][32:19], VEC[i][18:11], VEC[i][10]);
            check($sformatf("vector %0d", i), 32'(fetch_addr_o), 32'(VEC[i][9:0]));
        end

        // R9: literal visible during return-with-literal, before the edge
        @(negedge clk);
        flow_i = 4'd7; instr_i = 14'h31C5;
        #1;
        check("R9 literal", 32'(wlit_o), 32'hC5);
        check("R9 load flag", 32'(wlit_load_o), 32'h1);
        flow_i = 4'd0;
        #1;
        check("R9 flag idle", 32'(wlit_load_o), 32'h0);

        // R1: empty stack after reset
        do_reset();
        apply(4'd6, 14'h0, 8'h0, 1'b1);
        check("R1 empty stack", 32'(fetch_addr_o), 32'h000);

        // R10: overflow discards the oldest
        do_reset();
        apply(4'd5, 14'h2100, 8'h0, 1'b0);   // push 000
        apply(4'd5, 14'h2200, 8'h0, 1'b0);   // push 101
        apply(4'd5, 14'h2300, 8'h0, 1'b0);   // push 201
        check("R10 third call", 32'(fetch_addr_o), 32'h300);
        apply(4'd6, 14'h0, 8'h0, 1'b0);
        check("R10 first return", 32'(fetch_addr_o), 32'h201);
        apply(4'd6, 14'h0, 8'h0, 1'b0);
        check("R10 second return", 32'(fetch_addr_o), 32'h101);
        apply(4'd7, 14'h3100, 8'h0, 1'b0);
        check("R11 repeat bottom", 32'(fetch_addr_o), 32'h101);

        // R5: short call on page 1 returns past it
        apply(4'd3, 14'h3042, 8'h0, 1'b1);
        check("R5 page call", 32'(fetch_addr_o), 32'h242);
        apply(4'd6, 14'h0, 8'h0, 1'b0);
        check("R5 return addr", 32'(fetch_addr_o), 32'h102);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule